// File: doc/BRIEF.md
# Coin Credit Accumulator

This block keeps the credit of a vending machine. Three one-hot coin lines say which coin the sensor saw: a nickel, a dime or a quarter. A separate strobe marks the moment that coin is valid. On each strobe, the block adds that coin's value to a stored credit. It raises a purchase flag once the credit reaches thirty cents.

The credit is held in five-cent units, so a nickel is worth 1, a dime 2 and a quarter 5. The purchase threshold is 6 units. The strobe may come from a slow or bouncing mechanical source. It is therefore passed through a synchronizer and reduced to a single rising-edge event, so a strobe held for many cycles adds its coin only once. Strobes that carry no coin, or more than one coin, are discarded.

The credit saturates at its largest value instead of wrapping. The active-low reset clears the credit and the flag.

Top module: `coin_vend_acc`

## Requirements
- R1: While `rst_n` is low and after it is released, `credit_o` is 0 and `buy_ok_o` is 0 until a coin is accepted.
- R2: An accepted coin adds its value in five-cent units to `credit_o`: `nickel_i` adds 1, `dime_i` adds 2 and `quarter_i` adds 5.
- R3: One rising edge of `coin_stb_i` adds a coin exactly once, however many cycles the strobe stays high.
- R4: A strobe edge on which the number of asserted coin lines is zero, two or three is ignored, and `credit_o` keeps its value.
- R5: `credit_o` saturates at 2^CREDIT_W-1 (15 units with the default CREDIT_W=4) instead of wrapping.
- R6: `buy_ok_o` is 1 exactly when `credit_o` is at least 6 units (thirty cents), and once high it stays high until reset.
- R7: With SYNC_STAGES=2, `coin_stb_i` driven high between edges first changes `credit_o` on the third rising clock edge after it rises.
- R8: Pulling `rst_n` low at any time clears `credit_o` and `buy_ok_o`.
- R9: Changes on the coin lines with `coin_stb_i` held low leave `credit_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coin_stb_i | input | 1 | Coin strobe, asynchronous to the clock, counted on its rising edge |
| nickel_i | input | 1 | Coin is a nickel |
| dime_i | input | 1 | Coin is a dime |
| quarter_i | input | 1 | Coin is a quarter |
| credit_o | output | CREDIT_W | Accumulated credit in five-cent units |
| buy_ok_o | output | 1 | Credit has reached the purchase threshold |

## Verification
Saturation and the threshold flag can act on the same event. A quarter that pushes the credit past 15 both clips the sum and must leave the flag set. The bench drives the credit up to the ceiling with quarters and then adds more coins. It judges that `credit_o` stays at 15 and that `buy_ok_o` never drops. The threshold boundary itself is approached from 5 units with a nickel, so that the flag rises on the same edge as the credit reaches 6.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

  typedef enum logic [2:0] {
    COIN_NONE    = 3'd0,
    COIN_NICKEL  = 3'd1,
    COIN_DIME    = 3'd2,
    COIN_QUARTER = 3'd3,
    COIN_MULTI   = 3'd4
  } coin_kind_e;

  // Classifies the three coin lines; anything but a single line is unusable.
  function automatic coin_kind_e classify(input logic n, input logic d, input logic q);
    unique case ({q, d, n})
      3'b000:  classify = COIN_NONE;
      3'b001:  classify = COIN_NICKEL;
      3'b010:  classify = COIN_DIME;
      3'b100:  classify = COIN_QUARTER;
      default: classify = COIN_MULTI;
    endcase
  endfunction

endpackage

// File: rtl/coin_strobe_sync.sv
module coin_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_async,
  output logic stb_rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= stb_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign stb_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/coin_decode.sv
module coin_decode
  import coin_vend_pkg::*;
#(
  parameter int UNIT_W        = 4,
  parameter int NICKEL_UNITS  = 1,
  parameter int DIME_UNITS    = 2,
  parameter int QUARTER_UNITS = 5
) (
  input  logic              nickel,
  input  logic              dime,
  input  logic              quarter,
  output logic              valid,
  output logic [UNIT_W-1:0] units
);

  coin_kind_e kind;

  always_comb begin
    kind  = classify(nickel, dime, quarter);
    valid = 1'b1;
    units = '0;
    case (kind)
      COIN_NICKEL:  units = UNIT_W'(NICKEL_UNITS);
      COIN_DIME:    units = UNIT_W'(DIME_UNITS);
      COIN_QUARTER: units = UNIT_W'(QUARTER_UNITS);
      default:      valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/coin_credit_reg.sv
module coin_credit_reg #(
  parameter int CREDIT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add_en,
  input  logic [CREDIT_W-1:0] add_units,
  output logic [CREDIT_W-1:0] credit
);

  localparam logic [CREDIT_W-1:0] CEIL = {CREDIT_W{1'b1}};

  // Saturating add: the carry out selects the ceiling.
  function automatic logic [CREDIT_W-1:0] sat_add(input logic [CREDIT_W-1:0] a,
                                                  input logic [CREDIT_W-1:0] b);
    logic [CREDIT_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[CREDIT_W] ? CEIL : wide[CREDIT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      credit <= '0;
    else if (add_en) credit <= sat_add(credit, add_units);
  end

endmodule

// File: rtl/coin_vend_acc.sv
module coin_vend_acc #(
  parameter int CREDIT_W      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int NICKEL_UNITS  = 1,
  parameter int DIME_UNITS    = 2,
  parameter int QUARTER_UNITS = 5,
  parameter int BUY_UNITS     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coin_stb_i,
  input  logic                nickel_i,
  input  logic                dime_i,
  input  logic                quarter_i,
  output logic [CREDIT_W-1:0] credit_o,
  output logic                buy_ok_o
);

  localparam logic [CREDIT_W-1:0] BUY_LVL = CREDIT_W'(BUY_UNITS);

  logic                coin_evt;
  logic                coin_valid;
  logic                coin_accept;
  logic [CREDIT_W-1:0] coin_units;

  coin_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_async (coin_stb_i),
    .stb_rise  (coin_evt)
  );

  coin_decode #(
    .UNIT_W        (CREDIT_W),
    .NICKEL_UNITS  (NICKEL_UNITS),
    .DIME_UNITS    (DIME_UNITS),
    .QUARTER_UNITS (QUARTER_UNITS)
  ) dec_i (
    .nickel  (nickel_i),
    .dime    (dime_i),
    .quarter (quarter_i),
    .valid   (coin_valid),
    .units   (coin_units)
  );

  assign coin_accept = coin_evt & coin_valid;

  coin_credit_reg #(.CREDIT_W(CREDIT_W)) acc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_en    (coin_accept),
    .add_units (coin_units),
    .credit    (credit_o)
  );

  assign buy_ok_o = (credit_o >= BUY_LVL);

endmodule

// File: rtl/coin_vend_acc_chk.sv
module coin_vend_acc_chk #(
  parameter int CREDIT_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                coin_evt,
  input logic                nickel_i,
  input logic                dime_i,
  input logic                quarter_i,
  input logic [CREDIT_W-1:0] credit_o,
  input logic                buy_ok_o
);

  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    coin_evt |=> !coin_evt);

  a_r4_reject_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (coin_evt && $countones({nickel_i, dime_i, quarter_i}) != 1) |=> $stable(credit_o));

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    coin_evt |=> (credit_o >= $past(credit_o)));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    buy_ok_o |=> buy_ok_o);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !coin_evt |=> $stable(credit_o));

endmodule

bind coin_vend_acc coin_vend_acc_chk #(.CREDIT_W(CREDIT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .coin_evt  (coin_evt),
  .nickel_i  (nickel_i),
  .dime_i    (dime_i),
  .quarter_i (quarter_i),
  .credit_o  (credit_o),
  .buy_ok_o  (buy_ok_o)
);

// File: tb/coin_vend_acc_tb.sv
`timescale 1ns/1ps
module coin_vend_acc_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0;
  logic       n = 1'b0, d = 1'b0, q = 1'b0;
  logic [3:0] credit;
  logic       buy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  coin_vend_acc dut_i (
    .clk(clk), .rst_n(rst_n), .coin_stb_i(stb),
    .nickel_i(n), .dime_i(d), .quarter_i(q),
    .credit_o(credit), .buy_ok_o(buy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // Expected flag from the credit, in five-cent units.
  function automatic int want_buy(input int c);
    return (c >= 6) ? 1 : 0;
  endfunction

  task automatic insert(input logic cn, input logic cd, input logic cq, input int hold);
    @(negedge clk);
    n = cn; d = cd; q = cq; stb = 1'b1;
    cycles(hold);
    stb = 1'b0;
    cycles(4);
    n = 0; d = 0; q = 0;
    cycles(1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cycles(1);
    chk("R8 credit in reset", credit, 0);
    chk("R8 flag in reset", buy, 0);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic t_reset_state();
    chk("R1 credit after reset", credit, 0);
    chk("R1 flag after reset", buy, 0);
  endtask

  task automatic t_values();
    do_reset();
    insert(1, 0, 0, 5); chk("R2 nickel", credit, 1);
    insert(0, 1, 0, 5); chk("R2 dime", credit, 3);
    insert(0, 0, 1, 5); chk("R2 quarter", credit, 8);
    chk("R6 flag at 8", buy, want_buy(8));
  endtask

  task automatic t_threshold();
    do_reset();
    insert(0, 0, 1, 5); chk("R6 credit 5", credit, 5);
    chk("R6 flag below threshold", buy, 0);
    insert(1, 0, 0, 5); chk("R6 credit 6", credit, 6);
    chk("R6 flag at threshold", buy, 1);
  endtask

  task automatic t_long_hold();
    do_reset();
    insert(0, 1, 0, 30); chk("R3 long strobe adds once", credit, 2);
    insert(0, 1, 0, 1);  chk("R3 short strobe", credit, 4);
  endtask

  task automatic t_invalid();
    do_reset();
    insert(1, 0, 0, 5); chk("R4 base", credit, 1);
    insert(0, 0, 0, 5); chk("R4 no coin line", credit, 1);
    insert(1, 1, 0, 5); chk("R4 two lines", credit, 1);
    insert(0, 1, 1, 5); chk("R4 dime+quarter", credit, 1);
    insert(1, 1, 1, 5); chk("R4 three lines", credit, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    insert(0, 0, 1, 5); insert(0, 0, 1, 5); insert(0, 0, 1, 5);
    chk("R5 at ceiling", credit, 15);
    insert(1, 0, 0, 5); chk("R5 nickel at ceiling", credit, 15);
    chk("R6 flag held at ceiling", buy, 1);
    insert(0, 0, 1, 5); chk("R5 quarter at ceiling", credit, 15);
    do_reset();
    insert(0, 0, 1, 5); insert(0, 0, 1, 5); insert(0, 1, 0, 5);
    chk("R5 reach 12", credit, 12);
    insert(0, 0, 1, 5); chk("R5 12+5 clips", credit, 15);
  endtask

  task automatic t_latency();
    do_reset();
    @(negedge clk);
    q = 1; stb = 1;
    @(negedge clk); chk("R7 after edge 1", credit, 0);
    @(negedge clk); chk("R7 after edge 2", credit, 0);
    @(negedge clk); chk("R7 after edge 3", credit, 5);
    stb = 0; cycles(4); q = 0;
  endtask

  task automatic t_idle_lines();
    do_reset();
    insert(0, 1, 0, 5);
    @(negedge clk); n = 1; cycles(3); n = 0; d = 1; q = 1; cycles(3); d = 0; q = 0; cycles(3);
    chk("R9 lines without strobe", credit, 2);
  endtask

  task automatic t_mid_reset();
    do_reset();
    insert(0, 0, 1, 5); insert(0, 1, 0, 5);
    chk("R8 before reset", buy, 1);
    do_reset();
    chk("R8 credit cleared", credit, 0);
    chk("R8 flag cleared", buy, 0);
  endtask

  initial begin
    cycles(3);
    chk("R1 credit during reset", credit, 0);
    rst_n = 1'b1;
    cycles(2);
    t_reset_state();
    t_values();
    t_threshold();
    t_long_hold();
    t_invalid();
    t_saturate();
    t_latency();
    t_idle_lines();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule